// File: doc/BRIEF.md
# Countdown Timer with Locked Reload and Interrupt

This block is a register-mapped 32-bit timer that counts downward. Software chooses one of four tick sources and writes a reload value. It sets the interrupt enable and then starts the counter. From that point the count drops by one on every cycle that carries a pulse from the chosen source. When it reaches zero, a sticky pending flag is set. On the next chosen tick the counter refills from the reload value and keeps running. The live count can be read back at any time. Software writes a clear bit to drop the pending flag.

The reload value and the interrupt enable are frozen while the timer runs. To reprogram either one, software first stops the timer, then changes the setting, then starts it again. Each start reloads the counter, so every restart begins a full countdown from the programmed value. The four tick sources reach the block as single-cycle enable pulses that are already in the bus clock domain. They stand for a slow 32 kHz tick, a 26 MHz tick, a bus-derived tick and a peripheral-clock tick. The interrupt output is a level that follows the pending flag through the enable.

Top module: `tmr_countdown`

## Requirements
- R1: The count changes only on a clock edge where the timer runs and the selected tick pulse is high; it then drops by one, and otherwise it holds its value.
- R2: Control bits [5:4] choose the tick source: value k takes pulse tick_i[k] (0 = 32 kHz tick, 1 = 26 MHz tick, 2 = bus-derived tick, 3 = peripheral-clock tick). Pulses on the other three inputs have no effect on the count.
- R3: Writing control bit 0 (run) from 0 to 1 loads the count from the reload value at that edge. This load takes precedence over any tick in the same cycle.
- R4: A selected tick that moves the count from 1 to 0 sets the pending flag. A selected tick that finds the count at 0 refills it from the reload value, and the timer keeps running.
- R5: A write to the reload register (word 1) is ignored while run is set.
- R6: A write to the interrupt-enable bit (word 3, bit 0) is ignored while run is set. It is accepted while the timer is stopped.
- R7: Writing 1 to word 3 bit 2 clears the pending flag, which reads back at word 3 bit 1 and cannot be written. When a set and a clear fall in the same cycle, the flag ends up set. Bit 2 reads as 0.
- R8: irq_o is high exactly when the pending flag and the interrupt enable are both set.
- R9: After reset the timer is stopped, source 0 is selected, the reload value and the count are both 0xFFFFFFFF, and the pending flag and the interrupt enable are both 0.
- R10: The current count reads at word 2 at any time. Writes to word 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word index: 0 control, 1 reload, 2 count, 3 interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| tick_i | input | 4 | One single-cycle enable pulse per tick source |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench aims at four corner cases:
- A set and a clear of the pending flag in the same cycle. A design where clear wins would drop the interrupt and lose an underflow.
- Writes to the reload value and to the interrupt enable while the timer runs. A design without the lock would let them change mid-count.
- A start that coincides with a tick. A design that lets the tick win would begin one count short.
- The refill after zero. A design that refilled on the 1-to-0 step, or that stopped at zero, would produce the wrong period.

Random traffic with small reload values, random source changes and random tick pulses is compared cycle by cycle against a reference model in the bench. This catches a wrong source index and updates on edges without a tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Word index of each register on the bus
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_IRQ    = 2'd3
  } reg_idx_e;

  // Bit positions inside the control word
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_SEL_LSB = 4;

  // Bit positions inside the interrupt word
  localparam int IRQ_EN_BIT   = 0;
  localparam int IRQ_PEND_BIT = 1;
  localparam int IRQ_CLR_BIT  = 2;

endpackage

// File: rtl/tmr_tick_select.sv
module tmr_tick_select #(
  parameter int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [N_SRC-1:0] hit;

  // One AND gate per source; a single bit survives for the decoded index.
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assign hit[k] = tick_i[k] && (sel_i == SEL_W'(k));
  end

  assign tick_o = |hit;

  always_comb begin
    AST_ONE_SOURCE: assert ($onehot0(hit)); // R2
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_hit_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             step_en;
  logic             at_zero;

  // Next value after one selected tick: drop by one, or refill from zero.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rel);
    return (cur == '0) ? rel : cur - ONE;
  endfunction

  // Whether one selected tick lands the count on zero.
  function automatic logic lands_on_zero(input logic [CNT_W-1:0] cur);
    return cur == ONE;
  endfunction

  assign step_en    = run_i && tick_i && !load_i;
  assign at_zero    = (count_q == '0);
  assign zero_hit_o = step_en && lands_on_zero(count_q);
  assign count_o    = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
    end else if (load_i) begin
      count_q <= reload_i;
    end else if (step_en) begin
      count_q <= next_count(count_q, reload_i);
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(run_i && tick_i)) |=> $stable(count_q)); // R1

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !at_zero) |=> (count_q == $past(count_q) - ONE)); // R1

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q == $past(reload_i))); // R3

  AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && at_zero) |=> (count_q == $past(reload_i))); // R4

  AST_ZERO_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit_o |=> (count_q == '0)); // R4

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic set_i,
  input  logic wr_i,
  input  logic en_d_i,
  input  logic clr_d_i,
  output logic pend_o,
  output logic en_o,
  output logic irq_o
);

  logic pend_q;
  logic en_q;
  logic clr_req;
  logic en_wr;

  assign clr_req = wr_i && clr_d_i;
  assign en_wr   = wr_i && !lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (set_i)        pend_q <= 1'b1;
      else if (clr_req) pend_q <= 1'b0;
      if (en_wr)        en_q   <= en_d_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = pend_q && en_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q); // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_i) |=> !pend_q); // R7

  AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(en_q)); // R6

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_req) |=> pend_q); // R4

endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0] tick_i,
  output logic             irq_o
);

  logic             run_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             tick_sel;
  logic             zero_hit;
  logic             pend;
  logic             irq_en;
  logic             wr_ctrl;
  logic             wr_reload;
  logic             wr_irq;
  logic             start_evt;
  reg_idx_e         idx;

  assign idx       = reg_idx_e'(bus_addr);
  assign wr_ctrl   = bus_we && (idx == REG_CTRL);
  assign wr_reload = bus_we && (idx == REG_RELOAD) && !run_q;
  assign wr_irq    = bus_we && (idx == REG_IRQ);
  assign start_evt = wr_ctrl && bus_wdata[CTRL_RUN_BIT] && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      sel_q    <= '0;
      reload_q <= '1;
    end else begin
      if (wr_ctrl) begin
        run_q <= bus_wdata[CTRL_RUN_BIT];
        sel_q <= bus_wdata[CTRL_SEL_LSB +: SEL_W];
      end
      if (wr_reload) reload_q <= bus_wdata;
    end
  end

  tmr_tick_select #(.N_SRC(N_SRC)) u_sel (
    .tick_i (tick_i),
    .sel_i  (sel_q),
    .tick_o (tick_sel)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_q),
    .load_i     (start_evt),
    .tick_i     (tick_sel),
    .reload_i   (reload_q),
    .count_o    (count),
    .zero_hit_o (zero_hit)
  );

  tmr_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_i  (run_q),
    .set_i   (zero_hit),
    .wr_i    (wr_irq),
    .en_d_i  (bus_wdata[IRQ_EN_BIT]),
    .clr_d_i (bus_wdata[IRQ_CLR_BIT]),
    .pend_o  (pend),
    .en_o    (irq_en),
    .irq_o   (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (idx)
      REG_CTRL: begin
        bus_rdata[CTRL_RUN_BIT]              = run_q;
        bus_rdata[CTRL_SEL_LSB +: SEL_W]     = sel_q;
      end
      REG_RELOAD: bus_rdata = reload_q;
      REG_COUNT:  bus_rdata = count;
      REG_IRQ: begin
        bus_rdata[IRQ_EN_BIT]   = irq_en;
        bus_rdata[IRQ_PEND_BIT] = pend;
      end
    endcase
  end

  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(reload_q)); // R5

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o |-> (pend && irq_en))); // R8

endmodule

// File: tb/tmr_countdown_tb.sv
module tmr_countdown_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick = '0;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit        m_run;
  bit [1:0]  m_sel;
  bit [31:0] m_reload;
  bit [31:0] m_count;
  bit        m_pend;
  bit        m_ien;

  always #5 clk = ~clk;

  tmr_countdown dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick), .irq_o(irq)
  );

  function automatic bit [31:0] model_read(input bit [1:0] a);
    case (a)
      2'd0: return {26'd0, m_sel, 3'd0, m_run};
      2'd1: return m_reload;
      2'd2: return m_count;
      default: return {29'd0, 1'b0, m_pend, m_ien};
    endcase
  endfunction

  function automatic string tag_of(input bit [1:0] a);
    case (a)
      2'd0: return "R2 R9 control";
      2'd1: return "R5 reload";
      2'd2: return "R1 R3 R4 R10 count";
      default: return "R6 R7 irq";
    endcase
  endfunction

  task automatic check(input string tag, input bit [31:0] got, input bit [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_step(input bit we, input bit [1:0] a, input bit [31:0] wd,
                            input bit [3:0] tk);
    bit set_p, clr_p, load;
    set_p = 0; clr_p = 0;
    load = we && a == 2'd0 && wd[0] && !m_run;
    if (load) m_count = m_reload;
    else if (m_run && tk[m_sel]) begin
      if (m_count == 0) m_count = m_reload;
      else begin
        if (m_count == 1) set_p = 1;
        m_count = m_count - 1;
      end
    end
    if (we && a == 2'd3) begin
      clr_p = wd[2];
      if (!m_run) m_ien = wd[0];
    end
    if (we && a == 2'd1 && !m_run) m_reload = wd;
    if (we && a == 2'd0) begin
      m_run = wd[0];
      m_sel = wd[5:4];
    end
    if (set_p) m_pend = 1;
    else if (clr_p) m_pend = 0;
  endtask

  // one bus cycle: drive, compare against the model, advance the model
  task automatic cyc(input bit we, input bit [1:0] a, input bit [31:0] wd, input bit [3:0] tk);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = wd; tick = tk;
    #1;
    check(tag_of(a), bus_rdata, model_read(a));
    check("R8 irq_o", {31'd0, irq}, {31'd0, m_pend & m_ien});
    @(posedge clk);
    model_step(we, a, wd, tk);
  endtask

  task automatic expect_lit(input string tag, input bit [1:0] a, input bit [31:0] v);
    @(negedge clk);
    bus_we = 0; bus_addr = a; tick = 0;
    #1;
    check(tag, bus_rdata, v);
    @(posedge clk);
    model_step(0, a, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    m_run = 0; m_sel = 0; m_reload = '1; m_count = '1; m_pend = 0; m_ien = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R9 reset state
    expect_lit("R9 ctrl", 2'd0, 32'h0);
    expect_lit("R9 reload", 2'd1, 32'hFFFF_FFFF);
    expect_lit("R9 count", 2'd2, 32'hFFFF_FFFF);
    expect_lit("R9 irq", 2'd3, 32'h0);

    cyc(1, 2'd1, 32'd2, 0);          // reload = 2
    cyc(1, 2'd3, 32'd1, 0);          // enable irq while stopped
    cyc(1, 2'd0, 32'h11, 0);         // run, source 1
    expect_lit("R3 start loads", 2'd2, 32'd2);
    cyc(0, 2'd2, 0, 4'b1101);        // other sources only
    expect_lit("R2 wrong source ignored", 2'd2, 32'd2);
    cyc(0, 2'd2, 0, 4'b0010);
    expect_lit("R1 one step", 2'd2, 32'd1);
    cyc(0, 2'd2, 0, 4'b0010);
    expect_lit("R4 pending set", 2'd3, 32'd3);
    check("R8 irq high", {31'd0, irq}, 32'd1);
    cyc(1, 2'd1, 32'd7, 0);
    expect_lit("R5 reload locked", 2'd1, 32'd2);
    cyc(1, 2'd3, 32'd0, 0);
    expect_lit("R6 enable locked", 2'd3, 32'd3);
    cyc(0, 2'd2, 0, 4'b0010);
    expect_lit("R4 refill", 2'd2, 32'd2);
    cyc(1, 2'd2, 32'd5, 0);
    expect_lit("R10 count read-only", 2'd2, 32'd2);
    cyc(0, 2'd2, 0, 4'b0010);        // count 1
    cyc(1, 2'd3, 32'h4, 4'b0010);    // clear and set together
    expect_lit("R7 set wins", 2'd3, 32'd3);
    cyc(1, 2'd3, 32'h6, 0);          // clear (bit1 write ignored)
    expect_lit("R7 cleared", 2'd3, 32'd1);
    check("R8 irq low", {31'd0, irq}, 32'd0);
    cyc(1, 2'd0, 32'h10, 0);         // stop
    cyc(1, 2'd3, 32'd0, 0);
    expect_lit("R6 enable accepted when stopped", 2'd3, 32'd0);
    cyc(1, 2'd1, 32'd5, 0);
    cyc(1, 2'd0, 32'h11, 4'b1111);   // start with a tick in the same cycle
    expect_lit("R3 start beats tick", 2'd2, 32'd5);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      bit we;
      bit [1:0] a;
      bit [31:0] wd;
      bit [3:0] tk;
      we = ($urandom % 4) == 0;
      a  = 2'($urandom % 4);
      case (a)
        2'd0: wd = {26'd0, 2'($urandom), 3'd0, 1'(($urandom % 4) != 0)};
        2'd1: wd = (($urandom % 8) == 0) ? $urandom : 32'($urandom % 6);
        2'd3: wd = {29'd0, 3'($urandom)};
        default: wd = $urandom;
      endcase
      for (int b = 0; b < 4; b++) tk[b] = ($urandom % 3) != 0;
      cyc(we, a, wd, tk);
    end

    finish_run();
  end

endmodule